// File: doc/BRIEF.md
# Extended Configuration Register Responder

This block sits on the user side of a PCIe endpoint and holds a bank of configuration registers that the endpoint core does not implement itself. The core reports each configuration read or write that it receives from the link as a strobe lasting one clock cycle. Each strobe comes with a 10-bit DWORD register number and an 8-bit function number. A write also carries 32 data bits and four byte enables. The responder keeps only the registers in the externally owned window, which is DWORD 0x3A0 to 0x3FF (byte address 0xE80 to 0xFFF). It keeps one copy of that window for each of a parameterised number of functions. It ignores requests outside the window.

An accepted read is answered in a fixed slot. Data and a valid flag are driven during the clock cycle directly after the read strobe, so the core samples them on the next rising edge. A writes merges into the addressed register lane by lane.

The response path is a two-state machine. `RSP_IDLE` is the rest state. The transition *accept* (a read strobe whose register number is inside the window) moves it to `RSP_DRIVE`, where the captured word and the valid flag are presented for exactly one cycle. From `RSP_DRIVE`, another accepted read keeps it in `RSP_DRIVE` (the *chain* transition). Any other cycle takes the *release* transition back to `RSP_IDLE`. `RSP_IDLE` stays put when no read is accepted (*hold*).

Top module: `ecr_responder`

## Requirements
- R1: After reset, `rsp_rd_valid` is 0, `rsp_rd_data` is 0, and every stored register of every function reads back as 0.
- R2: A read strobe whose register number is in 0x3A0..0x3FF makes `rsp_rd_valid` high in the following cycle only, together with the addressed word on `rsp_rd_data`.
- R3: A read strobe whose register number is below 0x3A0 produces no response: `rsp_rd_valid` stays 0 in the following cycle.
- R4: A write strobe with all four byte enables set and an in-window register number stores the full 32-bit word. A later read of the same register and function returns that word.
- R5: In a write, byte enable bit k (k = 0..3) selects data bits 8k+7..8k. Each lane whose enable is set takes the new byte, and each lane whose enable is clear keeps its old byte. An all-zero enable field leaves the register unchanged.
- R6: Writes whose register number is outside the window change no stored register.
- R7: Each function number below `NUM_FUNCS` has its own independent copy of the window.
- R8: A function number of `NUM_FUNCS` or above, with an in-window register, still gets a response with valid high, but its data is 0. Its writes change no stored register.
- R9: `rsp_rd_data` is 0 in every cycle in which `rsp_rd_valid` is 0.
- R10: Read strobes in consecutive cycles are each answered in their own following cycle, in order.
- R11: A cycle without a read strobe, including a write-only cycle, leaves `rsp_rd_valid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rd_stb | input | 1 | Read-received strobe, one cycle |
| cfg_wr_stb | input | 1 | Write-received strobe, one cycle |
| cfg_reg_num | input | 10 | DWORD register number, valid with a strobe |
| cfg_func_num | input | 8 | Function number, valid with a strobe |
| cfg_wr_data | input | 32 | Write data, valid with the write strobe |
| cfg_wr_be | input | 4 | Write byte enables, bit k selects byte k |
| rsp_rd_data | output | 32 | Read response data, zero when not valid |
| rsp_rd_valid | output | 1 | Read response valid, single-cycle pulse |

## Verification
The bench builds the responder with `NUM_FUNCS` = 2 and the default window of 96 DWORDs. This makes the full register file only 192 words, so every register of both functions can be written with a distinct arithmetic pattern and read back. The small function count also lets the bench sweep every out-of-range function number from 2 to 255. It can sweep every register number below the window, including the 0x39F/0x3A0 edge, and all 16 byte-enable codes on one register, while comparing against a model computed in the bench.

// File: rtl/ecr_pkg.sv
package ecr_pkg;

    localparam int REG_W  = 10;
    localparam int FUNC_W = 8;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef enum logic [0:0] {
        RSP_IDLE  = 1'b0,
        RSP_DRIVE = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/ecr_decode.sv
module ecr_decode
    import ecr_pkg::*;
#(
    parameter int NUM_FUNCS = 2,
    parameter int WIN_BASE  = 'h3A0,
    parameter int WIN_WORDS = 96,
    parameter int IDX_W     = 7,
    parameter int FSEL_W    = 1
) (
    input  logic [REG_W-1:0]  reg_num,
    input  logic [FUNC_W-1:0] func_num,
    output logic              in_win,
    output logic              func_ok,
    output logic [IDX_W-1:0]  word_idx,
    output logic [FSEL_W-1:0] func_sel
);

    logic [REG_W-1:0] offset;

    // Subtracting the base wraps numbers below the window to large values,
    // so a single compare against the span covers both edges.
    always_comb begin
        offset   = reg_num - REG_W'(WIN_BASE);
        in_win   = (offset < REG_W'(WIN_WORDS));
        word_idx = offset[IDX_W-1:0];
        func_ok  = (func_num < FUNC_W'(NUM_FUNCS));
        func_sel = func_num[FSEL_W-1:0];
    end

endmodule

// File: rtl/ecr_lane_merge.sv
module ecr_lane_merge
    import ecr_pkg::*;
(
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    input  logic [BE_W-1:0]   lane_en,
    output logic [DATA_W-1:0] merged_word
);

    for (genvar lane = 0; lane < BE_W; lane++) begin : g_lane
        assign merged_word[lane*8 +: 8] = lane_en[lane] ? new_word[lane*8 +: 8]
                                                        : old_word[lane*8 +: 8];
    end

endmodule

// File: rtl/ecr_regfile.sv
module ecr_regfile
    import ecr_pkg::*;
#(
    parameter int NUM_FUNCS = 2,
    parameter int WIN_WORDS = 96,
    parameter int IDX_W     = 7,
    parameter int FSEL_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FSEL_W-1:0] wr_func,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [FSEL_W-1:0] rd_func,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] bank_rd [NUM_FUNCS];

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_func
        logic [DATA_W-1:0] words [WIN_WORDS];
        logic [DATA_W-1:0] merged;
        logic              sel;

        assign sel = wr_en && (wr_func == FSEL_W'(f));

        ecr_lane_merge u_merge (
            .old_word    (words[wr_idx]),
            .new_word    (wr_data),
            .lane_en     (wr_be),
            .merged_word (merged)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < WIN_WORDS; i++) begin
                    words[i] <= '0;
                end
            end else if (sel) begin
                words[wr_idx] <= merged;
            end
        end

        assign bank_rd[f] = words[rd_idx];
    end

    assign rd_word = bank_rd[rd_func];

endmodule

// File: rtl/ecr_rsp_fsm.sv
module ecr_rsp_fsm
    import ecr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_accept,
    input  logic [DATA_W-1:0] rd_word,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    rsp_state_e        state_q;
    rsp_state_e        state_d;
    logic [DATA_W-1:0] data_q;

    // next-state: accept / chain enter or stay in RSP_DRIVE, release / hold go idle
    always_comb begin
        state_d = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE:  state_d = rd_accept ? RSP_DRIVE : RSP_IDLE;
            RSP_DRIVE: state_d = rd_accept ? RSP_DRIVE : RSP_IDLE;
            default:   state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= rd_accept ? rd_word : '0;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            RSP_IDLE: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            RSP_DRIVE: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
            default: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
        endcase
    end

endmodule

// File: rtl/ecr_responder.sv
module ecr_responder
    import ecr_pkg::*;
#(
    parameter int NUM_FUNCS = 4,
    parameter int WIN_BASE  = 'h3A0,
    parameter int WIN_LAST  = 'h3FF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_rd_stb,
    input  logic                 cfg_wr_stb,
    input  logic [REG_W-1:0]     cfg_reg_num,
    input  logic [FUNC_W-1:0]    cfg_func_num,
    input  logic [DATA_W-1:0]    cfg_wr_data,
    input  logic [BE_W-1:0]      cfg_wr_be,
    output logic [DATA_W-1:0]    rsp_rd_data,
    output logic                 rsp_rd_valid
);

    localparam int WIN_WORDS = WIN_LAST - WIN_BASE + 1;
    localparam int IDX_W     = (WIN_WORDS > 1) ? $clog2(WIN_WORDS) : 1;
    localparam int FSEL_W    = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;

    logic              in_win;
    logic              func_ok;
    logic [IDX_W-1:0]  word_idx;
    logic [FSEL_W-1:0] func_sel;
    logic [DATA_W-1:0] bank_word;
    logic [DATA_W-1:0] rd_word;
    logic              rd_accept;
    logic              wr_accept;

    ecr_decode #(
        .NUM_FUNCS (NUM_FUNCS),
        .WIN_BASE  (WIN_BASE),
        .WIN_WORDS (WIN_WORDS),
        .IDX_W     (IDX_W),
        .FSEL_W    (FSEL_W)
    ) u_decode (
        .reg_num  (cfg_reg_num),
        .func_num (cfg_func_num),
        .in_win   (in_win),
        .func_ok  (func_ok),
        .word_idx (word_idx),
        .func_sel (func_sel)
    );

    assign rd_accept = cfg_rd_stb && in_win;
    assign wr_accept = cfg_wr_stb && in_win && func_ok;

    ecr_regfile #(
        .NUM_FUNCS (NUM_FUNCS),
        .WIN_WORDS (WIN_WORDS),
        .IDX_W     (IDX_W),
        .FSEL_W    (FSEL_W)
    ) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_accept),
        .wr_func (func_sel),
        .wr_idx  (word_idx),
        .wr_data (cfg_wr_data),
        .wr_be   (cfg_wr_be),
        .rd_func (func_sel),
        .rd_idx  (word_idx),
        .rd_word (bank_word)
    );

    // functions beyond the implemented count read as zero
    assign rd_word = func_ok ? bank_word : '0;

    ecr_rsp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_accept (rd_accept),
        .rd_word   (rd_word),
        .rd_valid  (rsp_rd_valid),
        .rd_data   (rsp_rd_data)
    );

endmodule

// File: rtl/ecr_responder_chk.sv
module ecr_responder_chk #(
    parameter int NUM_FUNCS = 4,
    parameter int WIN_BASE  = 'h3A0,
    parameter int WIN_LAST  = 'h3FF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_rd_stb,
    input logic        cfg_wr_stb,
    input logic [9:0]  cfg_reg_num,
    input logic [7:0]  cfg_func_num,
    input logic [31:0] rsp_rd_data,
    input logic        rsp_rd_valid
);

    logic [9:0] span_off;
    logic       hit;
    logic       bad_func;

    assign span_off = cfg_reg_num - 10'(WIN_BASE);
    assign hit      = span_off < 10'(WIN_LAST - WIN_BASE + 1);
    assign bad_func = cfg_func_num >= 8'(NUM_FUNCS);

    assert_in_window_answer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_stb && hit) |=> rsp_rd_valid);

    assert_out_window_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_stb && !hit) |=> !rsp_rd_valid);

    assert_bad_func_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_stb && hit && bad_func) |=> (rsp_rd_valid && rsp_rd_data == 32'h0));

    assert_idle_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_rd_valid |-> (rsp_rd_data == 32'h0));

    assert_no_strobe_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rd_stb) |=> !rsp_rd_valid);

    assert_write_only_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_stb && !cfg_rd_stb) |=> !rsp_rd_valid);

endmodule

bind ecr_responder ecr_responder_chk #(
    .NUM_FUNCS (NUM_FUNCS),
    .WIN_BASE  (WIN_BASE),
    .WIN_LAST  (WIN_LAST)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rd_stb   (cfg_rd_stb),
    .cfg_wr_stb   (cfg_wr_stb),
    .cfg_reg_num  (cfg_reg_num),
    .cfg_func_num (cfg_func_num),
    .rsp_rd_data  (rsp_rd_data),
    .rsp_rd_valid (rsp_rd_valid)
);

// File: tb/tb_ecr_responder.sv
module tb_ecr_responder;

    localparam int NF    = 2;
    localparam int BASE  = 'h3A0;
    localparam int WORDS = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rd_stb = 1'b0;
    logic        cfg_wr_stb = 1'b0;
    logic [9:0]  cfg_reg_num = '0;
    logic [7:0]  cfg_func_num = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [3:0]  cfg_wr_be = '0;
    logic [31:0] rsp_rd_data;
    logic        rsp_rd_valid;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    logic [31:0] model [NF][WORDS];

    always #10 clk = ~clk;

    ecr_responder #(.NUM_FUNCS(NF), .WIN_BASE(BASE), .WIN_LAST(BASE + WORDS - 1)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_rd_stb   (cfg_rd_stb),
        .cfg_wr_stb   (cfg_wr_stb),
        .cfg_reg_num  (cfg_reg_num),
        .cfg_func_num (cfg_func_num),
        .cfg_wr_data  (cfg_wr_data),
        .cfg_wr_be    (cfg_wr_be),
        .rsp_rd_data  (rsp_rd_data),
        .rsp_rd_valid (rsp_rd_valid)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int k = 0; k < 4; k++) if (be[k]) r[k*8 +: 8] = n[k*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] pat(int f, int i);
        return 32'h9E37_79B9 * 32'(f * WORDS + i + 1);
    endfunction

    task automatic do_write(int f, int r, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        cfg_wr_stb = 1'b1; cfg_func_num = f[7:0]; cfg_reg_num = r[9:0];
        cfg_wr_data = d; cfg_wr_be = be;
        if (r >= BASE && r < BASE + WORDS && f < NF)
            model[f][r - BASE] = merge(model[f][r - BASE], d, be);
        @(negedge clk);
        cfg_wr_stb = 1'b0; cfg_wr_data = '0; cfg_wr_be = '0;
        chk(rsp_rd_valid == 1'b0, "R11 write-only valid", 32'(rsp_rd_valid), 32'h0);
    endtask

    task automatic do_read(int f, int r, string tag);
        logic        ev;
        logic [31:0] ed;
        ev = (r >= BASE && r < BASE + WORDS);
        ed = (ev && f < NF) ? model[f][r - BASE] : 32'h0;
        @(negedge clk);
        cfg_rd_stb = 1'b1; cfg_func_num = f[7:0]; cfg_reg_num = r[9:0];
        @(negedge clk);
        cfg_rd_stb = 1'b0;
        chk(rsp_rd_valid == ev, {tag, " valid"}, 32'(rsp_rd_valid), 32'(ev));
        chk(rsp_rd_data == ed, {tag, " data"}, rsp_rd_data, ed);
    endtask

    task automatic read_all(string tag);
        for (int f = 0; f < NF; f++)
            for (int i = 0; i < WORDS; i++) do_read(f, BASE + i, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        for (int f = 0; f < NF; f++)
            for (int i = 0; i < WORDS; i++) model[f][i] = '0;
        repeat (3) @(negedge clk);
        chk(rsp_rd_valid == 1'b0, "R1 reset valid", 32'(rsp_rd_valid), 32'h0);
        chk(rsp_rd_data == 32'h0, "R1 reset data", rsp_rd_data, 32'h0);
        rst_n = 1'b1;

        // R1: every register cleared
        read_all("R1 cleared");

        // R4 / R7: distinct full-word pattern per function and register
        for (int f = 0; f < NF; f++)
            for (int i = 0; i < WORDS; i++) do_write(f, BASE + i, pat(f, i), 4'hF);
        read_all("R4 R7 full write");

        // R5: all sixteen byte-enable codes on one register
        for (int be = 0; be < 16; be++) begin
            do_write(0, BASE + 5, 32'hA5C3_9E10 ^ (32'h0101_0101 * 32'(be + 1)), be[3:0]);
            do_read(0, BASE + 5, "R5 lane merge");
        end

        // R2: pulse lasts one cycle, and R9 data returns to zero
        do_read(1, BASE + WORDS - 1, "R2 last word");
        @(negedge clk);
        chk(rsp_rd_valid == 1'b0, "R2 single pulse", 32'(rsp_rd_valid), 32'h0);
        chk(rsp_rd_data == 32'h0, "R9 idle data", rsp_rd_data, 32'h0);

        // R3 / R6: every register number below the window
        for (int r = 0; r < BASE; r++) begin
            do_write(r % NF, r, 32'hFFFF_FFFF, 4'hF);
            do_read(r % NF, r, "R3 out of window");
        end
        read_all("R6 out-window write ignored");

        // R8: every unimplemented function number
        for (int f = NF; f < 256; f++) begin
            do_write(f, BASE + (f % WORDS), 32'hDEAD_BEEF, 4'hF);
            do_read(f, BASE + (f % WORDS), "R8 bad function");
        end
        read_all("R8 bad-function write ignored");

        // R10: back-to-back reads
        @(negedge clk);
        cfg_rd_stb = 1'b1; cfg_func_num = 8'd0; cfg_reg_num = 10'(BASE);
        @(negedge clk);
        chk(rsp_rd_valid == 1'b1, "R10 first valid", 32'(rsp_rd_valid), 32'h1);
        chk(rsp_rd_data == model[0][0], "R10 first data", rsp_rd_data, model[0][0]);
        cfg_func_num = 8'd1; cfg_reg_num = 10'(BASE + 7);
        @(negedge clk);
        chk(rsp_rd_valid == 1'b1, "R10 second valid", 32'(rsp_rd_valid), 32'h1);
        chk(rsp_rd_data == model[1][7], "R10 second data", rsp_rd_data, model[1][7]);
        cfg_func_num = 8'd0; cfg_reg_num = 10'(BASE - 1);
        @(negedge clk);
        cfg_rd_stb = 1'b0;
        chk(rsp_rd_valid == 1'b0, "R10 R3 chained miss", 32'(rsp_rd_valid), 32'h0);
        chk(rsp_rd_data == 32'h0, "R9 chained miss data", rsp_rd_data, 32'h0);
        @(negedge clk);
        chk(rsp_rd_valid == 1'b0, "R11 quiet", 32'(rsp_rd_valid), 32'h0);

        finish_run();
    end

endmodule